// File: doc/BRIEF.md
# Grouped Input Debounce Filter with Capture

This block cleans up raw digital input pins before the controller's scan logic samples them. Each of the 36 pins passes through a two-flop synchronizer and then a time-domain stability filter. A new level reaches the filtered output only after the synchronized pin has held that level for a programmed number of time units. An ON or OFF interval shorter than that time is dropped, and the filtered output keeps its old level.

The pins are split into six groups. Each group has its own 4-bit filter length from 1 to 15 units. A length of 0 turns the filter off, so the output follows the synchronized pin. The four narrow groups can each pick a fine unit (0.1 ms) or a coarse unit (1 ms). The two wide groups always use the coarse unit. A shared prescaler makes both unit ticks from the clock: one fine unit is `CYC_PER_FINE` cycles, and one coarse unit is ten fine units.

Each pin also has a capture latch, which the scan logic can enable pin by pin. The latch holds a pulse that is shorter than one scan until the scan logic reads it. A read strobe clears the latch only if the filtered level has already gone low. So a pulse that arrives while a read is in progress is not lost.

Top module: `grouped_input_filter`

## Requirements
- R1: While rst_ni is low and right after it is released, filt_o and cap_o are all zero.
- R2: Each pin passes through two synchronizer flops. With a group length of 0, a change on pin_i appears on filt_o after the third rising clock edge, and a single-cycle pulse is passed through.
- R3: With group length L greater than 0, a level that differs from filt_o for no more than (L-1) units never reaches filt_o. This holds for both an ON interval and an OFF interval, and filt_o keeps its previous level.
- R4: With group length L greater than 0, a level held for at least L units is copied to filt_o.
- R5: Groups 0 to 3 use the fine unit (CYC_PER_FINE cycles) when their bit in fine_sel_i is 1, and the coarse unit (10 fine units) when it is 0. Bit g of fine_sel_i belongs to group g.
- R6: Groups 4 and 5 always use the coarse unit, whatever the value of fine_sel_i.
- R7: Pins 0-3, 4-7, 8-11 and 12-15 form groups 0 to 3. Pins 16-23 form group 4, and pins 24-35 form group 5. Group g takes its length from grp_len_i[4g+3:4g], and that length affects only its own pins.
- R8: When capture is enabled for a pin, cap_o goes high once the pin's filtered level is high. It stays high after the pulse ends, until a read strobe.
- R9: scan_rd_i clears cap_o only for pins whose filtered level is low. A read while the filtered level is still high leaves cap_o set.
- R10: When a pin's bit in cap_en_i is 0, its cap_o stays 0 even when filtered pulses occur.
- R11: If the synchronized pin returns to the filtered level before the filter time has passed, the stability count restarts. Two short ON intervals separated by a brief OFF gap are rejected, even though together they are longer than the filter time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 36 | Raw input pins, not synchronized |
| grp_len_i | input | 24 | Filter length per group, 4 bits each; 0 turns the filter off |
| fine_sel_i | input | 4 | Fine-unit select for groups 0 to 3 |
| cap_en_i | input | 36 | Capture enable per pin |
| scan_rd_i | input | 1 | Scan-read strobe that clears captures |
| filt_o | output | 36 | Filtered levels |
| cap_o | output | 36 | Captured levels |

## Verification
The filter is driven with single pulses whose lengths sit just below and just at the acceptance threshold, in every group and under both unit choices. This shows that the unit is chosen per group and that the wide groups ignore the fine select. A second pattern uses two sub-threshold pulses separated by a short gap, which tells a counter that restarts apart from one that accumulates. An OFF dip below threshold checks that filtering works in both directions. The capture tests place a read strobe both after the filtered pulse has ended and while it is still high, which separates an unconditional clear from the guarded one.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  localparam int NUM_IN      = 36;
  localparam int NUM_GRP     = 6;
  localparam int NARROW_W    = 4;
  localparam int NUM_NARROW  = 4;
  localparam int WIDE_W      = 8;
  localparam int LEN_W       = 4;
  localparam int FINE_GRPS   = NUM_NARROW;

  function automatic int grp_of(input int idx);
    if (idx < NARROW_W * NUM_NARROW) return idx / NARROW_W;
    else if (idx < NARROW_W * NUM_NARROW + WIDE_W) return NUM_NARROW;
    else return NUM_NARROW + 1;
  endfunction
endpackage

// File: rtl/dbf_tick_gen.sv
module dbf_tick_gen #(
  parameter int CYC_PER_FINE    = 10000,
  parameter int FINE_PER_COARSE = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fine_tick_o,
  output logic coarse_tick_o
);
  localparam int CW = (CYC_PER_FINE > 1) ? $clog2(CYC_PER_FINE) : 1;
  localparam int FW = (FINE_PER_COARSE > 1) ? $clog2(FINE_PER_COARSE) : 1;

  logic [CW-1:0] cyc_q;
  logic [FW-1:0] fine_q;
  logic          fine_wrap, coarse_wrap;

  assign fine_wrap   = (cyc_q == CW'(CYC_PER_FINE - 1));
  assign coarse_wrap = (fine_q == FW'(FINE_PER_COARSE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      fine_q <= '0;
    end else begin
      cyc_q <= fine_wrap ? '0 : cyc_q + 1'b1;
      if (fine_wrap) fine_q <= coarse_wrap ? '0 : fine_q + 1'b1;
    end
  end

  assign fine_tick_o   = fine_wrap;
  assign coarse_tick_o = fine_wrap && coarse_wrap;

  generate
    if (CYC_PER_FINE > 1) begin : g_gap_chk
      // R5
      fine_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fine_tick_o |=> !fine_tick_o);
    end
    if (FINE_PER_COARSE > 1) begin : g_coarse_chk
      // R5
      coarse_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        coarse_tick_o |=> !coarse_tick_o);
    end
  endgenerate
endmodule

// File: rtl/dbf_chan.sv
module dbf_chan #(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             unit_tick_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             cap_en_i,
  input  logic             scan_rd_i,
  output logic             filt_o,
  output logic             cap_o
);
  logic             s1_q, s2_q, filt_q, cap_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (len_i == '0) begin
      filt_q <= s2_q;
      cnt_q  <= '0;
    end else if (s2_q == filt_q) begin
      cnt_q <= '0;
    end else if (unit_tick_i) begin
      if (cnt_inc >= {1'b0, len_i}) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_inc[LEN_W-1:0];
      end
    end
  end

  // set while filtered high; read clears only once filtered is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else         cap_q <= cap_en_i & (filt_q | (cap_q & ~scan_rd_i));
  end

  assign filt_o = filt_q;
  assign cap_o  = cap_q;

  // R3
  filt_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(s2_q)));
  // R4
  filt_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((filt_q != $past(filt_q)) && ($past(len_i) != '0)) |-> $past(unit_tick_i));
  // R9
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cap_q) && $past(filt_q) && $past(cap_en_i)) |-> cap_q);
  // R10
  cap_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q |-> $past(cap_en_i));
endmodule

// File: rtl/grouped_input_filter.sv
module grouped_input_filter
  import dbf_pkg::*;
#(
  parameter int CYC_PER_FINE    = 10000,
  parameter int FINE_PER_COARSE = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_IN-1:0]          pin_i,
  input  logic [NUM_GRP*LEN_W-1:0]   grp_len_i,
  input  logic [FINE_GRPS-1:0]       fine_sel_i,
  input  logic [NUM_IN-1:0]          cap_en_i,
  input  logic                       scan_rd_i,
  output logic [NUM_IN-1:0]          filt_o,
  output logic [NUM_IN-1:0]          cap_o
);
  logic               fine_tick, coarse_tick;
  logic [NUM_GRP-1:0] unit_tick;

  dbf_tick_gen #(
    .CYC_PER_FINE   (CYC_PER_FINE),
    .FINE_PER_COARSE(FINE_PER_COARSE)
  ) u_tick (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fine_tick_o  (fine_tick),
    .coarse_tick_o(coarse_tick)
  );

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      if (g < FINE_GRPS) begin : g_sel
        assign unit_tick[g] = fine_sel_i[g] ? fine_tick : coarse_tick;
      end else begin : g_coarse
        assign unit_tick[g] = coarse_tick;
      end
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
      localparam int GRP = grp_of(i);
      dbf_chan #(.LEN_W(LEN_W)) u_chan (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (pin_i[i]),
        .unit_tick_i(unit_tick[GRP]),
        .len_i      (grp_len_i[GRP*LEN_W +: LEN_W]),
        .cap_en_i   (cap_en_i[i]),
        .scan_rd_i  (scan_rd_i),
        .filt_o     (filt_o[i]),
        .cap_o      (cap_o[i])
      );
    end
  endgenerate

  // R6
  wide_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_tick[NUM_GRP-1] || unit_tick[NUM_GRP-2]) |-> coarse_tick);
endmodule

// File: tb/grouped_input_filter_test.sv
module grouped_input_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPF        = 4;
  localparam int FINE_U     = CPF;
  localparam int COARSE_U   = CPF * 10;

  typedef struct packed {
    logic [7:0]  pin;
    logic [3:0]  len;
    logic        fine;
    logic [11:0] per;
    logic        acc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd0,  4'd3,  1'b1, 12'd12,  1'b1},  // R4 R5 fine
    '{8'd0,  4'd3,  1'b1, 12'd8,   1'b0},  // R3 R5
    '{8'd5,  4'd2,  1'b0, 12'd80,  1'b1},  // R4 R5 coarse
    '{8'd5,  4'd2,  1'b0, 12'd40,  1'b0},  // R3 R5
    '{8'd5,  4'd2,  1'b1, 12'd8,   1'b1},  // R5 fine on group 1
    '{8'd14, 4'd15, 1'b1, 12'd60,  1'b1},  // R4 max length
    '{8'd14, 4'd15, 1'b1, 12'd56,  1'b0},  // R3 max length
    '{8'd20, 4'd4,  1'b1, 12'd120, 1'b0},  // R6 fine ignored
    '{8'd20, 4'd4,  1'b1, 12'd160, 1'b1},  // R6
    '{8'd30, 4'd1,  1'b1, 12'd40,  1'b1},  // R6 R4 len 1
    '{8'd35, 4'd0,  1'b0, 12'd1,   1'b1},  // R2 bypass
    '{8'd10, 4'd0,  1'b0, 12'd1,   1'b1}   // R2 bypass group 2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] pin = '0;
  logic [23:0] grp_len = '0;
  logic [3:0]  fine_sel = '0;
  logic [35:0] cap_en = '0;
  logic        scan_rd = 1'b0;
  logic [35:0] filt, cap;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grouped_input_filter #(.CYC_PER_FINE(CPF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .grp_len_i(grp_len),
    .fine_sel_i(fine_sel), .cap_en_i(cap_en), .scan_rd_i(scan_rd),
    .filt_o(filt), .cap_o(cap)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int unit_of(input int p, input logic f);
    return (f && p < 16) ? FINE_U : COARSE_U;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    // R1
    check("R1 filt in reset", filt, '0);
    check("R1 cap in reset", cap, '0);
    rst_n = 1'b1;
    cyc(1);
    check("R1 filt after reset", filt, '0);
    check("R1 cap after reset", cap, '0);

    // table walk, capture disabled
    for (int v = 0; v < NV; v++) begin
      automatic int p = int'(VECS[v].pin);
      automatic int l = int'(VECS[v].len);
      automatic int u = unit_of(p, VECS[v].fine);
      automatic int per = int'(VECS[v].per);
      automatic logic seen = 1'b0;
      grp_len  = {6{VECS[v].len}};
      fine_sel = {4{VECS[v].fine}};
      cyc(2 * l * u + 20);
      pin[p] = 1'b1;
      for (int c = 0; c < per; c++) begin
        cyc(1);
        seen |= filt[p];
      end
      pin[p] = 1'b0;
      for (int c = 0; c < l * u + 8; c++) begin
        cyc(1);
        seen |= filt[p];
      end
      check($sformatf("R3/R4 vec %0d pin %0d", v, p), {35'd0, seen}, {35'd0, VECS[v].acc});
      cyc(2 * l * u + 20);
      check($sformatf("R10 no capture vec %0d", v), cap, '0);
    end

    // R2 latency with filter off
    grp_len = '0;
    cyc(2);
    pin[35] = 1'b1;
    cyc(2);
    check("R2 two edges", {35'd0, filt[35]}, 36'd0);
    cyc(1);
    check("R2 third edge", {35'd0, filt[35]}, 36'd1);
    pin[35] = 1'b0;
    cyc(4);

    // R7 group isolation: group 0 off, group 1 length 15 coarse
    grp_len = 24'h0000F0;
    fine_sel = '0;
    cyc(2);
    pin[3] = 1'b1; pin[4] = 1'b1;
    cyc(2);
    pin[3] = 1'b0; pin[4] = 1'b0;
    cyc(1);
    check("R7 group 0 bypass pin 3", filt & 36'h18, 36'h08);
    cyc(10);
    check("R7 group 1 holds pin 4", filt & 36'h18, 36'h00);

    // R11 count restart on a short gap
    grp_len = 24'h000003;
    fine_sel = 4'b0001;
    cyc(20);
    pin[1] = 1'b1; cyc(8);
    pin[1] = 1'b0; cyc(3);
    pin[1] = 1'b1; cyc(8);
    pin[1] = 1'b0;
    begin
      automatic logic seen = 1'b0;
      for (int c = 0; c < 30; c++) begin
        cyc(1);
        seen |= filt[1];
      end
      check("R11 restart rejects split pulse", {35'd0, seen}, 36'd0);
    end

    // R3 short OFF dip keeps high level
    pin[2] = 1'b1;
    cyc(20);
    check("R4 pin 2 accepted high", {35'd0, filt[2]}, 36'd1);
    pin[2] = 1'b0; cyc(8);
    pin[2] = 1'b1;
    begin
      automatic logic dip = 1'b0;
      for (int c = 0; c < 20; c++) begin
        cyc(1);
        dip |= ~filt[2];
      end
      check("R3 OFF dip discarded", {35'd0, dip}, 36'd0);
    end
    pin[2] = 1'b0;
    cyc(20);
    check("R4 pin 2 accepted low", {35'd0, filt[2]}, 36'd0);

    // R8 capture of single-cycle pulse, filter off on group 5
    grp_len = '0;
    cap_en = '1;
    cyc(2);
    pin[33] = 1'b1; cyc(1); pin[33] = 1'b0;
    cyc(10);
    check("R8 capture held", {35'd0, cap[33]}, 36'd1);
    check("R8 filtered back low", {35'd0, filt[33]}, 36'd0);
    scan_rd = 1'b1; cyc(1); scan_rd = 1'b0;
    check("R8 read clears", {35'd0, cap[33]}, 36'd0);

    // R9 read while filtered still high
    pin[33] = 1'b1;
    cyc(6);
    scan_rd = 1'b1; cyc(1); scan_rd = 1'b0;
    cyc(1);
    check("R9 read during high keeps", {35'd0, cap[33]}, 36'd1);
    pin[33] = 1'b0;
    cyc(6);
    check("R9 held after fall", {35'd0, cap[33]}, 36'd1);
    scan_rd = 1'b1; cyc(1); scan_rd = 1'b0;
    check("R9 later read clears", {35'd0, cap[33]}, 36'd0);

    // R10 disabled pin next to an enabled one
    cap_en = 36'h100000000;
    pin[31] = 1'b1; pin[32] = 1'b1; cyc(1);
    pin[31] = 1'b0; pin[32] = 1'b0;
    cyc(6);
    check("R10 only enabled pin captures", cap & 36'h180000000, 36'h100000000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule